// File: doc/BRIEF.md
# Short-Address DMA Channel

This block is one DMA channel that moves data between memory and a peripheral without processor involvement. It is configured through four write-only register slots. Transfers run in one of two address forms. In single-address form, only the memory address goes onto the bus, and an acknowledge strobe selects the peripheral, so each transfer is one bus cycle. In dual-address form, each transfer is a read followed by a write between a 24-bit memory address and a 16-bit I/O address. The I/O address is placed on the bus with all upper bits set to one.

Each transfer starts from a request input. The channel first asks for the bus and waits for a grant. It then makes its access or accesses and drops its bus request for at least one cycle before it can start another transfer. The memory address can count up, count down or stay fixed. A transfer counter ends the run. In repeat mode, the channel reloads its starting address and count and keeps going. A one-cycle interrupt pulse marks the end of each count.

Register slots on `cfg_sel`: 0 is the memory address, 1 is the I/O address, 2 is the transfer count and 3 is control. The control byte has these bits: bit0 enable, bit1 dual-address, bit2 direction (0 moves memory to peripheral, 1 moves peripheral to memory), bits[4:3] address mode (0 sequential, 1 idle, 2 repeat), bit5 count down, bit6 word unit, bit7 interrupt enable.

Top module: `sadma_channel`

## Requirements
- R1: After reset, bus_req, bus_rd, bus_wr, dack and tend_irq are all low.
- R2: bus_req stays high until bus_gnt arrives, and no bus access is made while bus_gnt is low.
- R3: A single-address transfer is one bus cycle. In that cycle bus_addr is the memory address and dack is high. bus_rd is high when direction is 0 and bus_wr is high when direction is 1.
- R4: A dual-address transfer is a read in one cycle and a write in the next cycle. Direction 0 reads the memory address and writes {8'hFF, I/O address}. Direction 1 does the reverse. The write data equals the data that was read.
- R5: After the last access of each transfer, bus_req is low for at least one cycle.
- R6: In sequential mode, the memory address moves after each transfer by 1 (byte) or 2 (word). It moves down if bit5 is set and up otherwise. The I/O address never changes.
- R7: In idle mode, the memory address stays the same for every transfer.
- R8: A count value N from 1 to 65535 gives exactly N transfers, and 0 gives 65536. After the last transfer the enable bit clears, and further requests start no bus activity.
- R9: In repeat mode, the end of the count reloads the starting memory address and count, and the channel stays enabled.
- R10: tend_irq is high for exactly one cycle, the cycle after the final access of a count, and only if bit7 is set.
- R11: A register write made while a transfer is in progress (from the request being accepted until the bus is released) is ignored.
- R12: bus_size equals the word-unit bit during every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register slot select |
| cfg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Transfer request, sampled while idle |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read access strobe |
| bus_wr | output | 1 | Write access strobe |
| bus_size | output | 1 | 1 = word access, 0 = byte access |
| bus_wdata | output | 16 | Write data for dual-address writes |
| bus_rdata | input | 16 | Read data, valid in the read cycle |
| dack | output | 1 | Peripheral acknowledge for single-address cycles |
| tend_irq | output | 1 | End-of-count interrupt pulse |

## Verification
When xfer_req is sampled high in idle, bus_req rises at the next edge. The first access happens in the cycle after the edge at which bus_gnt is seen. A dual-address write follows its read one cycle later. bus_req is low in the cycle after the last access, and tend_irq is high in that same cycle. The scoreboard does not wait for a fixed number of cycles. It holds expected accesses and interrupts in order and compares each one at the falling edge of the cycle in which it shows up. The bench waits a fixed eight cycles after each request pulse, which is longer than the five-cycle worst case. Any extra or missing access therefore appears as an out-of-order item, an unexpected item or a non-empty queue.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ACC1 = 3'd2,
    ST_ACC2 = 3'd3,
    ST_REL  = 3'd4
  } ch_state_t;

  typedef enum logic [1:0] {
    MD_SEQ  = 2'd0,
    MD_HOLD = 2'd1,
    MD_RPT  = 2'd2,
    MD_RSVD = 2'd3
  } addr_mode_t;

  typedef struct packed {
    logic       ien;
    logic       word;
    logic       down;
    logic [1:0] mode;
    logic       dir;
    logic       dual;
    logic       en;
  } ch_ctrl_t;

  localparam logic [1:0] SEL_MEM  = 2'd0;
  localparam logic [1:0] SEL_IO   = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/sadma_fsm.sv
module sadma_fsm
  import sadma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      dual,
  input  logic      xfer_req,
  input  logic      bus_gnt,
  output ch_state_t state,
  output logic      upd
);

  ch_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (en && xfer_req) state_d = ST_REQ;
      ST_REQ:  if (bus_gnt) state_d = ST_ACC1;
      ST_ACC1: state_d = dual ? ST_ACC2 : ST_REL;
      ST_ACC2: state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
  // last access of a transfer: bookkeeping updates at the end of this cycle
  assign upd = ((state_q == ST_ACC1) && !dual) || (state_q == ST_ACC2);

endmodule

// File: rtl/sadma_addr_gen.sv
module sadma_addr_gen #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          reload,
  input  logic          down,
  input  logic          word,
  output logic [AW-1:0] cur
);

  logic [AW-1:0] base_q, base_d, cur_q, cur_d, stride;

  assign stride = word ? AW'(2) : AW'(1);

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    if (ld) begin
      base_d = ld_val;
      cur_d  = ld_val;
    end else if (reload) begin
      cur_d = base_q;
    end else if (step) begin
      cur_d = down ? (cur_q - stride) : (cur_q + stride);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/sadma_xfer_cnt.sv
module sadma_xfer_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec_en,
  input  logic         reload,
  output logic         term
);

  logic [W-1:0] base_q, base_d, cur_q, cur_d;

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    if (ld) begin
      base_d = ld_val;
      cur_d  = ld_val;
    end else if (reload) begin
      cur_d = base_q;
    end else if (dec_en) begin
      cur_d = cur_q - W'(1);   // a load of 0 wraps, giving the full 2**W run
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
    end
  end

  assign term = (cur_q == W'(1));

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
  import sadma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16,
  parameter int DW     = 16,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              xfer_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [MEM_AW-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_size,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic              dack,
  output logic              tend_irq
);

  localparam int PAD_W  = MEM_AW - IO_AW;
  localparam int CTRL_W = $bits(ch_ctrl_t);

  ch_state_t          state;
  logic               upd, term, fin, reload, clr_en, step;
  logic               cfg_ok, ld_mem, ld_io, ld_cnt, ld_ctrl;
  ch_ctrl_t           ctrl_q, ctrl_d;
  logic [IO_AW-1:0]   io_q, io_d;
  logic [DW-1:0]      data_q, data_d;
  logic               irq_q, irq_d;
  logic [MEM_AW-1:0]  mem_cur, io_ext;

  // configuration accepted only while no transfer is in progress
  assign cfg_ok  = cfg_we && (state == ST_IDLE);
  assign ld_mem  = cfg_ok && (cfg_sel == SEL_MEM);
  assign ld_io   = cfg_ok && (cfg_sel == SEL_IO);
  assign ld_cnt  = cfg_ok && (cfg_sel == SEL_CNT);
  assign ld_ctrl = cfg_ok && (cfg_sel == SEL_CTRL);

  assign fin    = upd && term;
  assign reload = fin && (ctrl_q.mode == MD_RPT);
  assign clr_en = fin && (ctrl_q.mode != MD_RPT);
  assign step   = upd && (ctrl_q.mode != MD_HOLD) && !reload;

  sadma_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q.en),
    .dual     (ctrl_q.dual),
    .xfer_req (xfer_req),
    .bus_gnt  (bus_gnt),
    .state    (state),
    .upd      (upd)
  );

  sadma_addr_gen #(.AW(MEM_AW)) u_mem_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ld_mem),
    .ld_val (cfg_wdata[MEM_AW-1:0]),
    .step   (step),
    .reload (reload),
    .down   (ctrl_q.down),
    .word   (ctrl_q.word),
    .cur    (mem_cur)
  );

  sadma_xfer_cnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ld_cnt),
    .ld_val (cfg_wdata[CNT_W-1:0]),
    .dec_en (upd),
    .reload (reload),
    .term   (term)
  );

  // I/O addresses live in the top page of the memory map
  generate
    if (PAD_W > 0) begin : g_io_pad
      assign io_ext = {{PAD_W{1'b1}}, io_q};
    end else begin : g_io_flat
      assign io_ext = io_q[MEM_AW-1:0];
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (ld_ctrl)     ctrl_d = ch_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    else if (clr_en) ctrl_d.en = 1'b0;
  end

  always_comb begin
    io_d = io_q;
    if (ld_io) io_d = cfg_wdata[IO_AW-1:0];
  end

  always_comb begin
    data_d = data_q;
    if ((state == ST_ACC1) && ctrl_q.dual) data_d = bus_rdata;
  end

  assign irq_d = fin && ctrl_q.ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      io_q   <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      io_q   <= io_d;
      data_q <= data_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    dack      = 1'b0;
    case (state)
      ST_ACC1: begin
        if (!ctrl_q.dual) begin
          bus_addr = mem_cur;
          dack     = 1'b1;
          bus_rd   = !ctrl_q.dir;
          bus_wr   = ctrl_q.dir;
        end else begin
          bus_addr = ctrl_q.dir ? io_ext : mem_cur;
          bus_rd   = 1'b1;
        end
      end
      ST_ACC2: begin
        bus_addr  = ctrl_q.dir ? mem_cur : io_ext;
        bus_wr    = 1'b1;
        bus_wdata = data_q;
      end
      default: ;
    endcase
  end

  assign bus_req  = (state == ST_REQ) || (state == ST_ACC1) || (state == ST_ACC2);
  assign bus_size = ctrl_q.word;
  assign tend_irq = irq_q;

endmodule

// File: rtl/sadma_channel_chk.sv
module sadma_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_rd,
  input logic bus_wr,
  input logic dack,
  input logic tend_irq
);

  // R2
  access_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_gnt);

  // R2
  req_held_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R3
  ack_one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_rd ^ bus_wr));

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !dack) |=> (bus_wr && !dack && !bus_rd));

  // R5
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack || bus_wr) |=> !bus_req);

  // R10
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tend_irq |=> !tend_irq);

  // R10
  irq_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend_irq) |-> (!bus_req && $past(dack || bus_wr)));

endmodule

bind sadma_channel sadma_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .dack     (dack),
  .tend_irq (tend_irq)
);

// File: tb/sadma_channel_tb_top.sv
module sadma_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_req = 1'b0;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic [23:0] bus_addr;
  logic        bus_rd, bus_wr, bus_size;
  logic [15:0] bus_wdata, bus_rdata;
  logic        dack, tend_irq;
  logic        gnt_hold = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [23:0] addr;
    bit          rd, wr, ack, size, chk_data;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  sadma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dack(dack), .tend_irq(tend_irq)
  );

  // memory/peripheral model: read data is a function of the address
  assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;

  // arbiter model
  always @(negedge clk) bus_gnt <= bus_req && !gnt_hold;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor: pop and compare each access / interrupt as it appears
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bus_rd || bus_wr) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", $sformatf("unexpected access addr=%h rd=%0b wr=%0b, expected none",
                                       bus_addr, bus_rd, bus_wr));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(!e.is_irq && bus_addr == e.addr && bus_rd == e.rd && bus_wr == e.wr &&
                dack == e.ack && bus_size == e.size && bus_gnt &&
                (!e.chk_data || bus_wdata == e.data), e.tag,
                $sformatf("actual addr=%h rd=%0b wr=%0b ack=%0b size=%0b gnt=%0b wd=%h; expected irq=%0b addr=%h rd=%0b wr=%0b ack=%0b size=%0b gnt=1 wd=%h",
                          bus_addr, bus_rd, bus_wr, dack, bus_size, bus_gnt, bus_wdata,
                          e.is_irq, e.addr, e.rd, e.wr, e.ack, e.size, e.data));
        end
      end
      if (tend_irq) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "actual tend_irq=1, expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.is_irq, "R10", $sformatf("actual tend_irq=1, expected access at %h", e.addr));
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req(output bit saw_req);
    saw_req = 1'b0;
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    if (bus_req) saw_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (bus_req) saw_req = 1'b1;
    end
  endtask

  function automatic logic [7:0] mk_ctrl(bit en, bit dual, bit dir, logic [1:0] mode,
                                         bit down, bit word, bit ien);
    return {ien, word, down, mode, dir, dual, en};
  endfunction

  task automatic push_xfer(input logic [23:0] m, input logic [15:0] io, input logic [7:0] c,
                           input string tag);
    exp_t e;
    logic [23:0] io_ext;
    io_ext = {8'hFF, io};
    e.is_irq = 0; e.size = c[6]; e.tag = tag; e.data = '0; e.chk_data = 0;
    if (!c[1]) begin
      e.addr = m; e.rd = !c[2]; e.wr = c[2]; e.ack = 1;
      exp_q.push_back(e);
    end else begin
      e.addr = c[2] ? io_ext : m; e.rd = 1; e.wr = 0; e.ack = 0;
      exp_q.push_back(e);
      e.data = e.addr[15:0] ^ 16'h5A3C; e.chk_data = 1;
      e.addr = c[2] ? m : io_ext; e.rd = 0; e.wr = 1;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_irq(input string tag);
    exp_t e;
    e.is_irq = 1; e.addr = '0; e.rd = 0; e.wr = 0; e.ack = 0; e.size = 0;
    e.chk_data = 0; e.data = '0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // driver: program the channel, model each request, push expectations
  task automatic run_prog(input logic [23:0] m0, input logic [15:0] io, input logic [15:0] c0,
                          input logic [7:0] c, input int npulses, input string tag);
    logic [23:0] m;
    int rem, total;
    bit en, saw;
    m = m0; total = (c0 == 0) ? 65536 : int'(c0); rem = total; en = c[0];
    cfg_write(2'd0, {8'h00, m0});
    cfg_write(2'd1, {16'h0000, io});
    cfg_write(2'd2, {16'h0000, c0});
    cfg_write(2'd3, {24'h0, c});
    for (int p = 0; p < npulses; p++) begin
      if (en) begin
        push_xfer(m, io, c, tag);
        rem--;
        if (rem == 0) begin
          if (c[7]) push_irq("R10");
          if (c[4:3] == 2'd2) begin
            m = m0; rem = total;
          end else begin
            en = 0;
            if (c[4:3] != 2'd1) m = c[5] ? m - (c[6] ? 24'd2 : 24'd1) : m + (c[6] ? 24'd2 : 24'd1);
          end
        end else if (c[4:3] != 2'd1) begin
          m = c[5] ? m - (c[6] ? 24'd2 : 24'd1) : m + (c[6] ? 24'd2 : 24'd1);
        end
        pulse_req(saw);
      end else begin
        pulse_req(saw);
        // R8: a request after the count has finished starts no bus activity
        check(!saw, "R8", $sformatf("actual bus_req seen=%0b, expected 0", saw));
      end
    end
    check(exp_q.size() == 0, tag, $sformatf("actual pending=%0d, expected 0", exp_q.size()));
  endtask

  task automatic finish_sim();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_sim();
  end

  initial begin
    bit saw;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!bus_req && !bus_rd && !bus_wr && !dack && !tend_irq, "R1",
          $sformatf("actual req=%0b rd=%0b wr=%0b ack=%0b irq=%0b, expected all 0",
                    bus_req, bus_rd, bus_wr, dack, tend_irq));
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_req && !tend_irq, "R1", $sformatf("actual req=%0b irq=%0b after release, expected 0",
                                                  bus_req, tend_irq));

    // R3 R6 R8 R10: single-address, memory to peripheral, bytes counting up, count 3, one extra request
    run_prog(24'h001000, 16'h0040, 16'd3, mk_ctrl(1, 0, 0, 2'd0, 0, 0, 1), 4, "R3");
    // R3 R6 R12: single-address, peripheral to memory, words counting down, no interrupt (R10)
    run_prog(24'h002000, 16'h0044, 16'd2, mk_ctrl(1, 0, 1, 2'd0, 1, 1, 0), 3, "R6");
    // R4 R12: dual-address, memory to I/O, words counting up
    run_prog(24'h003000, 16'h1230, 16'd3, mk_ctrl(1, 1, 0, 2'd0, 0, 1, 1), 4, "R4");
    // R4 R7: dual-address, I/O to memory, idle mode keeps the memory address
    run_prog(24'h004000, 16'h2220, 16'd3, mk_ctrl(1, 1, 1, 2'd1, 0, 0, 1), 4, "R7");
    // R7: single-address, idle mode, word unit
    run_prog(24'h004800, 16'h0000, 16'd2, mk_ctrl(1, 0, 0, 2'd1, 1, 1, 0), 2, "R7");
    // R9: repeat mode reloads after every two transfers and stays enabled
    run_prog(24'h005000, 16'h0000, 16'd2, mk_ctrl(1, 0, 0, 2'd2, 0, 1, 1), 5, "R9");
    // R9: repeat, dual-address, counting down
    run_prog(24'h005800, 16'h3300, 16'd3, mk_ctrl(1, 1, 0, 2'd2, 1, 0, 1), 7, "R9");
    cfg_write(2'd3, 32'h0);
    pulse_req(saw);
    check(!saw, "R9", $sformatf("actual bus_req seen=%0b after disable, expected 0", saw));

    // R8: count 0 means 65536 - the channel is still running after 70 transfers
    run_prog(24'h006000, 16'h0000, 16'd0, mk_ctrl(1, 0, 0, 2'd0, 0, 0, 1), 70, "R8");
    cfg_write(2'd3, 32'h0);
    pulse_req(saw);
    check(!saw, "R8", $sformatf("actual bus_req seen=%0b after disable, expected 0", saw));

    // R2 R11: grant withheld; write the memory address while the request is pending
    cfg_write(2'd0, 32'h000100);
    cfg_write(2'd2, 32'd1);
    cfg_write(2'd3, {24'h0, mk_ctrl(1, 0, 0, 2'd0, 0, 0, 1)});
    gnt_hold = 1'b1;
    push_xfer(24'h000100, 16'h0000, mk_ctrl(1, 0, 0, 2'd0, 0, 0, 1), "R11");
    push_irq("R10");
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    repeat (4) @(negedge clk);
    check(bus_req && !bus_rd && !bus_wr, "R2",
          $sformatf("actual req=%0b rd=%0b wr=%0b while grant withheld, expected 1/0/0",
                    bus_req, bus_rd, bus_wr));
    cfg_write(2'd0, 32'h000900);   // R11: ignored
    gnt_hold = 1'b0;
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R11", $sformatf("actual pending=%0d, expected 0", exp_q.size()));
    // after the count ends the channel is idle and writes are taken again
    run_prog(24'h000A00, 16'h0000, 16'd1, mk_ctrl(1, 0, 1, 2'd0, 0, 0, 1), 2, "R11");

    repeat (4) @(negedge clk);
    finish_sim();
  end

endmodule